// File: doc/BRIEF.md
# Handshake Ripple Counter with Return-to-Zero Stages

This block is a binary counter built from a chain of one-bit stages. The stages pass count requests and replies to each other with return-to-zero handshakes rather than a shared count enable. Each stage holds one bit. A request from below either sets the bit and is answered at once with a "done" reply, or it finds the bit already set. In that case the stage forwards a request upward, waits for the stage above to reply, clears its bit and relays that reply downward. Replies come in two kinds on separate wires, "done" and "overflow". A carry that runs off the top of the chain therefore comes back to the bottom as an overflow reply.

The top stage has no neighbour above it. Its overflow input is tied to its own forward request, and its done input is held low, so a carry out of the top stage turns straight into an overflow reply. At the bottom, the environment raises a request and waits for one of the two replies. It then withdraws the request and waits for the reply to fall. The counter exposes all stage bits as a binary value. An entry gate holds back a request that is raised while the previous reply is still high, and lets it through once that reply has returned low. Every stage flags a request edge that arrives while it is waiting on the stage above.

Top module: `hs_ripple_counter`

## Requirements
- R1: After reset, value_o is 0, done_o, wrap_o and proto_err_o are 0.
- R2: A stage holding 0 that sees its request high sets its bit to 1 and raises its done reply, without forwarding a request upward.
- R3: A stage holding 1 that sees its request high raises its forward request and keeps its bit at 1 until a reply from above arrives; then it clears its bit and drops its forward request.
- R4: A stage relays an upward done as done and an upward overflow as overflow; at no time are both of its replies high.
- R5: Every stage reply stays high until the stage's request has fallen and the replies from above have fallen. A forward request stays high until a reply from above has arrived. At the top level, done_o or wrap_o stays high and value_o stays unchanged for as long as count_req_i is held high after the reply.
- R6: The top stage answers its own forward request with an overflow reply, because its done input is tied to 0.
- R7: Each completed handshake at count_req_i advances value_o by exactly one, modulo 2^WIDTH (value_o bit k is stage k's bit, bit 0 the stage at the environment).
- R8: The reply to a count is wrap_o when value_o moves from 2^WIDTH-1 to 0, and done_o for every other count. When wrap_o rises value_o is 0, and when done_o rises value_o is nonzero.
- R9: A request raised while done_o or wrap_o is still high is held back until both are low, and then counts exactly once.
- R10: proto_err_o is raised when a new request edge reaches a stage while it is waiting for a reply from above; a handshaking environment never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_req_i | input | 1 | Count request from the environment (return-to-zero) |
| done_o | output | 1 | Reply: count done, no wrap |
| wrap_o | output | 1 | Reply: count wrapped the value to 0 |
| value_o | output | WIDTH | Current count, binary |
| proto_err_o | output | 1 | Request edge seen by a stage awaiting its upper reply |

## Verification
The stage assertions take for granted that count_req_i obeys the four-phase rule. The request rises only when both replies are low, or is held back by the entry gate, and it is not withdrawn before a reply appears. The bench driver raises the request and then waits for a reply before withdrawing it. Its only departure from the rule is a deliberate early re-raise while the reply is still high, which the entry gate is meant to absorb. Under these inputs every inner handshake stays legal, so the bench expects the violation flag to remain low throughout.

// File: rtl/hs_counter_pkg.sv
package hs_counter_pkg;

  typedef enum logic [2:0] {
    ST_ZERO,   // bit 0, idle
    ST_SET,    // bit just set, done reply up
    ST_ONE,    // bit 1, idle
    ST_WAIT,   // bit 1, forward request up, awaiting reply
    ST_RELAY   // bit cleared, relaying upper reply
  } stage_st_e;

  function automatic logic stage_bit(input stage_st_e st);
    return (st == ST_SET) || (st == ST_ONE) || (st == ST_WAIT);
  endfunction

  function automatic logic reply_seen(input logic dn, input logic ov);
    return dn | ov;
  endfunction

endpackage

// File: rtl/hs_count_stage.sv
module hs_count_stage
  import hs_counter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_in,
  input  logic done_in,
  input  logic ovf_in,
  output logic done_out,
  output logic ovf_out,
  output logic req_out,
  output logic bit_o,
  output logic viol_o
);

  stage_st_e st_q;
  logic      req_in_q;
  logic      up_reply;
  logic      req_edge;

  assign up_reply = reply_seen(done_in, ovf_in);
  assign req_edge = req_in && !req_in_q;
  assign bit_o    = stage_bit(st_q);
  assign viol_o   = req_edge && (st_q == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_ZERO;
      req_in_q <= 1'b0;
      done_out <= 1'b0;
      ovf_out  <= 1'b0;
      req_out  <= 1'b0;
    end else begin
      req_in_q <= req_in;
      case (st_q)
        ST_ZERO: if (req_in) begin
          done_out <= 1'b1;
          st_q     <= ST_SET;
        end
        ST_SET: if (!req_in) begin
          done_out <= 1'b0;
          st_q     <= ST_ONE;
        end
        ST_ONE: if (req_in) begin
          req_out <= 1'b1;
          st_q    <= ST_WAIT;
        end
        ST_WAIT: if (up_reply) begin
          req_out  <= 1'b0;
          done_out <= done_in;
          ovf_out  <= ovf_in && !done_in;
          st_q     <= ST_RELAY;
        end
        ST_RELAY: if (!req_in && !up_reply) begin
          done_out <= 1'b0;
          ovf_out  <= 1'b0;
          st_q     <= ST_ZERO;
        end
        default: st_q <= ST_ZERO;
      endcase
    end
  end

  // R4: never both replies
  assert_one_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_out, ovf_out}));

  // R3: forward request only from a set bit
  assert_fwd_from_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_out) |-> $past(bit_o));

  // R5: forward request held until upper reply
  assert_fwd_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_out) |-> $past(up_reply));

  // R5: reply falls only after own request is low
  assert_reply_rtz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_out | ovf_out) |-> !$past(req_in));

  // R2: a reply rises only in answer to a request
  assert_reply_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_out | ovf_out) |-> $past(req_in));

  // R10: legal handshakes never hit a waiting stage
  assert_no_violation_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o);

endmodule

// File: rtl/hs_ripple_counter.sv
module hs_ripple_counter
  import hs_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_req_i,
  output logic             done_o,
  output logic             wrap_o,
  output logic [WIDTH-1:0] value_o,
  output logic             proto_err_o
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] st_req_in, st_done_in, st_ovf_in;
  logic [WIDTH-1:0] st_done_out, st_ovf_out, st_req_out, st_viol;
  logic             entry_req_q;
  logic             entry_reply;

  // entry gate: new request waits for the previous reply to return low
  assign entry_reply = reply_seen(st_done_out[0], st_ovf_out[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) entry_req_q <= 1'b0;
    else        entry_req_q <= count_req_i && (entry_req_q || !entry_reply);
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_bottom
        assign st_req_in[i] = entry_req_q;
      end else begin : g_inner
        assign st_req_in[i] = st_req_out[i-1];
      end
      if (i == TOP) begin : g_close
        assign st_done_in[i] = 1'b0;
        assign st_ovf_in[i]  = st_req_out[i];
      end else begin : g_link
        assign st_done_in[i] = st_done_out[i+1];
        assign st_ovf_in[i]  = st_ovf_out[i+1];
      end
      hs_count_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (st_req_in[i]),
        .done_in  (st_done_in[i]),
        .ovf_in   (st_ovf_in[i]),
        .done_out (st_done_out[i]),
        .ovf_out  (st_ovf_out[i]),
        .req_out  (st_req_out[i]),
        .bit_o    (value_o[i]),
        .viol_o   (st_viol[i])
      );
    end
  endgenerate

  assign done_o      = st_done_out[0];
  assign wrap_o      = st_ovf_out[0];
  assign proto_err_o = |st_viol;

  // R8: overflow at the bottom coincides with the value at zero
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_o) |-> (value_o == '0));

  // R8: a plain done reply leaves a nonzero value
  assert_done_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (value_o != '0));

  // R6: the top stage answers its forward request with overflow only
  assert_top_closure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done_out[TOP]) |-> !$past(st_req_out[TOP]));

endmodule

// File: tb/hs_ripple_counter_bench.sv
module hs_ripple_counter_bench;

  localparam int W   = 4;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         count_req_i = 1'b0;
  logic         done_o, wrap_o, proto_err_o;
  logic [W-1:0] value_o;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  int cycles = 0;
  int exp_val_q[$];
  bit exp_wrap_q[$];
  logic [1:0] prev_rep = 2'b00;

  always #10 clk = ~clk;

  hs_ripple_counter #(.WIDTH(W)) u_hs_ripple_counter (
    .clk(clk), .rst_n(rst_n), .count_req_i(count_req_i),
    .done_o(done_o), .wrap_o(wrap_o), .value_o(value_o),
    .proto_err_o(proto_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard driver side: expected result of the next count
  task automatic push_expect();
    exp_wrap_q.push_back(model == MOD - 1);
    model = (model + 1) % MOD;
    exp_val_q.push_back(model);
  endtask

  task automatic wait_reply(input bit level);
    int n = 0;
    while (((done_o | wrap_o) != level) && n < 400) begin
      @(negedge clk);
      n++;
    end
    check((done_o | wrap_o) == level, "R5 reply level reached", int'(done_o | wrap_o), int'(level));
  endtask

  task automatic do_count(input int hold);
    push_expect();
    @(negedge clk);
    count_req_i = 1'b1;
    wait_reply(1'b1);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check((done_o | wrap_o) && value_o == W'(model), "R5 reply held with request",
            int'(value_o), model);
    end
    count_req_i = 1'b0;
    wait_reply(1'b0);
    check(value_o == W'(model), "R7 value after handshake", int'(value_o), model);
    check(!proto_err_o, "R10 no violation", int'(proto_err_o), 0);
  endtask

  // scoreboard monitor: compare each rising reply with the queue head
  always @(negedge clk) begin
    if (rst_n) begin
      if ({wrap_o, done_o} != 2'b00 && prev_rep == 2'b00) begin
        check(!(wrap_o && done_o), "R4 single reply kind", int'({wrap_o, done_o}), 1);
        if (exp_val_q.size() == 0) begin
          check(1'b0, "R7 unexpected reply", int'(value_o), -1);
        end else begin
          int ev;
          bit ew;
          ev = exp_val_q.pop_front();
          ew = exp_wrap_q.pop_front();
          check(value_o == W'(ev), "R7 value at reply", int'(value_o), ev);
          check(wrap_o == ew, "R8 wrap reply kind", int'(wrap_o), int'(ew));
          check(done_o == !ew, "R2 R6 done reply kind", int'(done_o), int'(!ew));
        end
      end
      prev_rep <= {wrap_o, done_o};
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(value_o == '0 && !done_o && !wrap_o && !proto_err_o, "R1 reset state",
          int'({proto_err_o, wrap_o, done_o, value_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R7 R8: full cycle through wrap, then past it
    for (int c = 0; c < MOD + 3; c++) do_count(c % 3);
    // R5: long hold keeps reply and value steady
    do_count(30);
    // R9: re-raise while reply still high, counts once when it falls
    push_expect();
    @(negedge clk);
    count_req_i = 1'b1;
    wait_reply(1'b1);
    count_req_i = 1'b0;
    @(negedge clk);
    push_expect();
    count_req_i = 1'b1;
    wait_reply(1'b0);
    check(value_o == W'(model - 1), "R9 held-back request not yet counted",
          int'(value_o), model - 1);
    wait_reply(1'b1);
    check(value_o == W'(model), "R9 held-back request counted once", int'(value_o), model);
    count_req_i = 1'b0;
    wait_reply(1'b0);
    // R3 R6: run to the top again to exercise a full carry
    while (model != 0) do_count(1);
    check(exp_val_q.size() == 0, "R7 all expected replies seen", exp_val_q.size(), 0);
    check(!proto_err_o, "R10 flag low at end", int'(proto_err_o), 0);
    finish_run();
  end

endmodule